// File: doc/BRIEF.md
# Software Interrupt Dispatcher

The dispatcher accepts writes to a software-triggered interrupt register. Each write carries a 32-bit command word and the number of the CPU that issued it. From the command it takes an interrupt ID and a two-bit routing mode. The mode chooses the targets: the explicit CPU bitmap in the word, every CPU except the writer, the writer alone, or no CPU at all. For every target it pulses a pending-set strobe for that (target, ID) pair. It also records the writer as a source in a per-target, per-ID source bitmap.

A CPU interface acknowledges an interrupt by presenting its own CPU number and an ID. One cycle later the block returns an acknowledge word. That word holds the ID and the lowest-numbered source CPU still recorded for the pair, and that source is then retired. The security attribute bit of the command is stored with each request and returned on acknowledge. It is not enforced.

Top module: `sgi_dispatch`

## Requirements
- R1: While reset is held and right after it, every bit of set_strobe and pend_level is 0, ack_valid is 0 and ack_word equals 0x3FF.
- R2: The interrupt ID is taken from command bits 3:0. Each target t raises set_strobe bit t*16+ID for exactly one cycle, the cycle after the write.
- R3: Routing mode 00 (command bits 25:24) targets exactly the CPUs whose bits are set in command bits 23:16, with bit 16+n selecting CPU n. An all-zero bitmap raises nothing.
- R4: Routing mode 01 targets every CPU except the writer (wr_cpu).
- R5: Routing mode 10 targets only the writer.
- R6: Routing mode 11 raises no strobe and changes no recorded state.
- R7: pend_level bit t*16+ID is 1 exactly while at least one source CPU is recorded for target t and that ID. Requests from different sources accumulate.
- R8: An acknowledge (ack_en, ack_cpu, ack_id) for a non-empty pair sets ack_valid in the next cycle. ack_word then carries the ID in bits 9:0 and the lowest-numbered recorded source in bits 12:10, with all other bits 0. That source is removed from the record.
- R9: An acknowledge for an empty pair gives ack_valid 0 and ack_word 0x3FF in the next cycle, and changes nothing.
- R10: Command bit 15 is stored per pair by each accepted request. ack_secure returns the stored value with a valid acknowledge.
- R11: When a write and an acknowledge hit the same pair and source in the same cycle, the acknowledge reports the old request and the new request stays recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word |
| wr_cpu | input | 3 | CPU number of the writer |
| ack_en | input | 1 | Acknowledge request |
| ack_cpu | input | 3 | Acknowledging CPU |
| ack_id | input | 4 | Interrupt ID being acknowledged |
| set_strobe | output | 128 | One-cycle pending-set pulse per (target, ID) |
| pend_level | output | 128 | Per (target, ID): some source recorded |
| ack_valid | output | 1 | Acknowledge found a source |
| ack_word | output | 32 | ID and source of the acknowledge, or 0x3FF |
| ack_secure | output | 1 | Stored attribute of the acknowledged request |

## Verification
The bench targets the writer's own position in modes 01 and 10. A design that indexes the exclusion wrongly would strobe the writer, or would miss one CPU in the "all others" case. The bench also issues a reserved-mode command with a full bitmap, and an explicit-list command with an empty bitmap. Either one would leak strobes if the mode decode fell through to the list. Two sources are queued on one pair so that source order and retirement are visible: a design that cleared the whole record or picked the highest source would report the wrong source or lose the second one. A write and an acknowledge on the same pair in the same cycle show whether clearing is ordered after setting, which would drop the new request.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    typedef enum logic [1:0] {
        ROUTE_LIST   = 2'b00,
        ROUTE_OTHERS = 2'b01,
        ROUTE_SELF   = 2'b10,
        ROUTE_NONE   = 2'b11
    } sgi_route_e;

    localparam int unsigned ROUTE_LSB = 24;
    localparam int unsigned LIST_LSB  = 16;
    localparam int unsigned ATTR_BIT  = 15;
    localparam int unsigned SRC_LSB   = 10;
    localparam int unsigned ACK_ID_W  = 10;
    localparam logic [ACK_ID_W-1:0] NO_ID = '1;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode #(
    parameter int unsigned NUM_CPU = 8,
    localparam int unsigned CPU_W  = $clog2(NUM_CPU)
) (
    input  logic [1:0]         route,
    input  logic [NUM_CPU-1:0] list,
    input  logic [CPU_W-1:0]   req_cpu,
    output logic [NUM_CPU-1:0] tgt_mask
);
    import sgi_pkg::*;

    logic [NUM_CPU-1:0] self_bit;

    always_comb begin
        self_bit = {{(NUM_CPU-1){1'b0}}, 1'b1} << req_cpu;
        unique case (sgi_route_e'(route))
            ROUTE_LIST:   tgt_mask = list;
            ROUTE_OTHERS: tgt_mask = ~self_bit;
            ROUTE_SELF:   tgt_mask = self_bit;
            default:      tgt_mask = '0;
        endcase
    end
endmodule

// File: rtl/sgi_first_set.sv
module sgi_first_set #(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/sgi_slot_bank.sv
module sgi_slot_bank #(
    parameter int unsigned NUM_CPU = 8,
    parameter int unsigned NUM_ID  = 16,
    localparam int unsigned CPU_W  = $clog2(NUM_CPU),
    localparam int unsigned ID_W   = $clog2(NUM_ID)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ID_W-1:0]   set_id,
    input  logic [CPU_W-1:0]  set_src,
    input  logic              set_attr,
    input  logic              clr_en,
    input  logic [ID_W-1:0]   clr_id,
    output logic [NUM_ID-1:0] pend_o,
    output logic [NUM_ID-1:0] strobe_o,
    output logic              rsp_hit_o,
    output logic [CPU_W-1:0]  rsp_src_o,
    output logic              rsp_attr_o
);
    typedef struct packed {
        logic [NUM_ID-1:0][NUM_CPU-1:0] src;
        logic [NUM_ID-1:0]              attr;
        logic [NUM_ID-1:0]              strobe;
        logic                           hit;
        logic [CPU_W-1:0]               who;
        logic                           sec;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [CPU_W-1:0] clr_idx;
    logic             clr_any;

    sgi_first_set #(.W(NUM_CPU)) u_first (
        .vec (bank_q.src[clr_id]),
        .idx (clr_idx),
        .any (clr_any)
    );

    always_comb begin
        bank_d        = bank_q;
        bank_d.strobe = '0;
        bank_d.hit    = 1'b0;
        bank_d.who    = '0;
        bank_d.sec    = 1'b0;
        // retire first, then record: a same-cycle request survives
        if (clr_en && clr_any) begin
            bank_d.hit                  = 1'b1;
            bank_d.who                  = clr_idx;
            bank_d.sec                  = bank_q.attr[clr_id];
            bank_d.src[clr_id][clr_idx] = 1'b0;
        end
        if (set_en) begin
            bank_d.src[set_id][set_src] = 1'b1;
            bank_d.attr[set_id]         = set_attr;
            bank_d.strobe[set_id]       = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    for (genvar i = 0; i < NUM_ID; i++) begin : g_pend
        assign pend_o[i] = |bank_q.src[i];
    end

    assign strobe_o   = bank_q.strobe;
    assign rsp_hit_o  = bank_q.hit;
    assign rsp_src_o  = bank_q.who;
    assign rsp_attr_o = bank_q.sec;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
    parameter int unsigned NUM_CPU = 8,
    parameter int unsigned NUM_ID  = 16,
    localparam int unsigned CPU_W  = $clog2(NUM_CPU),
    localparam int unsigned ID_W   = $clog2(NUM_ID),
    localparam int unsigned SLOTS  = NUM_CPU * NUM_ID
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic             ack_en,
    input  logic [CPU_W-1:0] ack_cpu,
    input  logic [ID_W-1:0]  ack_id,
    output logic [SLOTS-1:0] set_strobe,
    output logic [SLOTS-1:0] pend_level,
    output logic             ack_valid,
    output logic [31:0]      ack_word,
    output logic             ack_secure
);
    import sgi_pkg::*;

    typedef struct packed {
        logic [ID_W-1:0] ack_id;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_CPU-1:0] tgt_mask;
    logic [ID_W-1:0]    cmd_id;
    logic               cmd_attr;
    logic               unused_cmd_bits;

    assign cmd_id          = wr_data[ID_W-1:0];
    assign cmd_attr        = wr_data[ATTR_BIT];
    assign unused_cmd_bits = ^{wr_data[31:26], wr_data[14:ID_W]};

    sgi_target_decode #(.NUM_CPU(NUM_CPU)) u_decode (
        .route    (wr_data[ROUTE_LSB +: 2]),
        .list     (wr_data[LIST_LSB +: NUM_CPU]),
        .req_cpu  (wr_cpu),
        .tgt_mask (tgt_mask)
    );

    logic [NUM_CPU-1:0] hit_w;
    logic [NUM_CPU-1:0] attr_w;
    logic [CPU_W-1:0]   src_w [NUM_CPU];

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
        sgi_slot_bank #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_en     (wr_en && tgt_mask[t]),
            .set_id     (cmd_id),
            .set_src    (wr_cpu),
            .set_attr   (cmd_attr),
            .clr_en     (ack_en && (ack_cpu == CPU_W'(t))),
            .clr_id     (ack_id),
            .pend_o     (pend_level[t*NUM_ID +: NUM_ID]),
            .strobe_o   (set_strobe[t*NUM_ID +: NUM_ID]),
            .rsp_hit_o  (hit_w[t]),
            .rsp_src_o  (src_w[t]),
            .rsp_attr_o (attr_w[t])
        );
    end

    always_comb begin
        top_d = top_q;
        if (ack_en) top_d.ack_id = ack_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    logic [CPU_W-1:0] rsp_src;

    always_comb begin
        rsp_src = '0;
        for (int t = 0; t < NUM_CPU; t++) begin
            rsp_src = rsp_src | src_w[t];
        end
        ack_valid  = |hit_w;
        ack_secure = |attr_w;
        ack_word   = '0;
        if (ack_valid) begin
            ack_word[ACK_ID_W-1:0]       = ACK_ID_W'(top_q.ack_id);
            ack_word[SRC_LSB +: CPU_W]   = rsp_src;
        end else begin
            ack_word[ACK_ID_W-1:0]       = NO_ID;
        end
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int unsigned NUM_CPU = 8,
    parameter int unsigned NUM_ID  = 16,
    localparam int unsigned CPU_W  = $clog2(NUM_CPU),
    localparam int unsigned SLOTS  = NUM_CPU * NUM_ID
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [CPU_W-1:0] wr_cpu,
    input logic             ack_en,
    input logic [SLOTS-1:0] set_strobe,
    input logic [SLOTS-1:0] pend_level,
    input logic             ack_valid,
    input logic [31:0]      ack_word,
    input logic             ack_secure
);
    a_r2_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_strobe) |-> $past(wr_en));

    a_r6_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'b11) |=> (set_strobe == '0));

    a_r5_self_single: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'b10) |=> ($countones(set_strobe) == 1));

    a_r4_others_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'b01 && 32'(wr_cpu) < NUM_CPU)
        |=> ($countones(set_strobe) == NUM_CPU - 1));

    a_r7_strobe_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_strobe & ~pend_level) == '0));

    a_r8_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack_en));

    a_r9_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |-> (ack_word == 32'h3FF && !ack_secure));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_cpu     (wr_cpu),
    .ack_en     (ack_en),
    .set_strobe (set_strobe),
    .pend_level (pend_level),
    .ack_valid  (ack_valid),
    .ack_word   (ack_word),
    .ack_secure (ack_secure)
);

// File: tb/test_sgi_dispatch.sv
module test_sgi_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam int NI = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   wr_cpu = '0;
    logic         ack_en = 1'b0;
    logic [2:0]   ack_cpu = '0;
    logic [3:0]   ack_id = '0;
    logic [127:0] set_strobe, pend_level;
    logic         ack_valid, ack_secure;
    logic [31:0]  ack_word;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_dispatch i_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_cpu(wr_cpu),
        .ack_en(ack_en), .ack_cpu(ack_cpu), .ack_id(ack_id),
        .set_strobe(set_strobe), .pend_level(pend_level),
        .ack_valid(ack_valid), .ack_word(ack_word), .ack_secure(ack_secure)
    );

    // reference model
    bit           mrec [NC][NI][NC];
    bit           mattr[NC][NI];
    logic [127:0] e_strobe = '0;
    bit           e_valid = 1'b0;
    logic [31:0]  e_word = 32'h3FF;
    bit           e_sec = 1'b0;

    always @(posedge clk) begin : model
        int c, id, r, f;
        bit hit;
        if (!rst_n) begin
            foreach (mrec[a, b, s]) mrec[a][b][s] = 1'b0;
            foreach (mattr[a, b]) mattr[a][b] = 1'b0;
            e_strobe = '0; e_valid = 0; e_word = 32'h3FF; e_sec = 0;
        end else begin
            e_strobe = '0; e_valid = 0; e_word = 32'h3FF; e_sec = 0;
            if (ack_en) begin
                c = ack_cpu; id = ack_id;
                for (int s = 0; s < NC; s++) begin
                    if (!e_valid && mrec[c][id][s]) begin
                        e_valid = 1; e_word = (s << 10) | id; e_sec = mattr[c][id];
                        mrec[c][id][s] = 0;
                    end
                end
            end
            if (wr_en) begin
                f = wr_data[25:24]; id = wr_data[3:0]; r = wr_cpu;
                for (int t = 0; t < NC; t++) begin
                    case (f)
                        0: hit = wr_data[16+t];
                        1: hit = (t != r);
                        2: hit = (t == r);
                        default: hit = 0;
                    endcase
                    if (hit) begin
                        mrec[t][id][r] = 1; mattr[t][id] = wr_data[15];
                        e_strobe[t*NI+id] = 1;
                    end
                end
            end
        end
    end

    function automatic logic [127:0] model_pend();
        logic [127:0] p = '0;
        for (int t = 0; t < NC; t++)
            for (int i = 0; i < NI; i++)
                for (int s = 0; s < NC; s++)
                    if (mrec[t][i][s]) p[t*NI+i] = 1'b1;
        return p;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("R2 strobe vs model", set_strobe, e_strobe);
        chk("R7 pend vs model", pend_level, model_pend());
        chk("R8 ack_valid vs model", 128'(ack_valid), 128'(e_valid));
        chk("R8 ack_word vs model", 128'(ack_word), 128'(e_word));
        chk("R10 ack_secure vs model", 128'(ack_secure), 128'(e_sec));
    end

    function automatic logic [31:0] cmd(int route, int list, int attr, int id);
        return {6'b0, 2'(route), 8'(list), 1'(attr), 11'b0, 4'(id)};
    endfunction

    function automatic logic [127:0] bitat(int t, int id);
        return 128'b1 << (t*NI + id);
    endfunction

    task automatic op(bit we, int wc, logic [31:0] wd, bit ae, int ac, int ai);
        @(negedge clk);
        wr_en = we; wr_cpu = 3'(wc); wr_data = wd;
        ack_en = ae; ack_cpu = 3'(ac); ack_id = 4'(ai);
        @(negedge clk);
        wr_en = 0; ack_en = 0;
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        logic [127:0] pend_before;
        logic [127:0] all_others;
        #1;
        chk("R1 strobe in reset", set_strobe, '0);
        chk("R1 ack_word in reset", 128'(ack_word), 128'h3FF);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pend after reset", pend_level, '0);
        chk("R1 ack_valid after reset", 128'(ack_valid), '0);

        // R3 explicit list, CPUs 0 and 2, id 3
        op(1, 0, cmd(0, 8'h05, 1, 3), 0, 0, 0);
        chk("R3 list strobes", set_strobe, bitat(0, 3) | bitat(2, 3));
        @(negedge clk);
        chk("R2 strobe is one cycle", set_strobe, '0);
        chk("R7 pend held", pend_level, bitat(0, 3) | bitat(2, 3));

        op(1, 1, cmd(0, 0, 0, 6), 0, 0, 0);
        chk("R3 empty list raises nothing", set_strobe, '0);

        // R4 others from CPU 2, id 5
        op(1, 2, cmd(1, 8'h00, 0, 5), 0, 0, 0);
        all_others = '0;
        for (int t = 0; t < NC; t++) if (t != 2) all_others |= bitat(t, 5);
        chk("R4 all but writer", set_strobe, all_others);

        // R5 self from CPU 6, id 9
        op(1, 6, cmd(2, 8'hFF, 0, 9), 0, 0, 0);
        chk("R5 writer only", set_strobe, bitat(6, 9));

        // R6 reserved mode with full list
        pend_before = pend_level;
        op(1, 3, cmd(3, 8'hFF, 1, 1), 0, 0, 0);
        chk("R6 reserved no strobe", set_strobe, '0);
        chk("R6 reserved no state", pend_level, pend_before);

        // R7/R8 two sources queued on target 0, id 7
        op(1, 4, cmd(0, 8'h01, 0, 7), 0, 0, 0);
        op(1, 1, cmd(0, 8'h01, 0, 7), 0, 0, 0);
        chk("R7 pend accumulate", 128'(pend_level[0*NI+7]), 128'd1);
        op(0, 0, 0, 1, 0, 7);
        chk("R8 first ack valid", 128'(ack_valid), 128'd1);
        chk("R8 first ack lowest source", 128'(ack_word), 128'((1 << 10) | 7));
        op(0, 0, 0, 1, 0, 7);
        chk("R8 second ack source", 128'(ack_word), 128'((4 << 10) | 7));
        chk("R7 pend cleared", 128'(pend_level[0*NI+7]), 128'd0);
        op(0, 0, 0, 1, 0, 7);
        chk("R9 empty ack valid", 128'(ack_valid), 128'd0);
        chk("R9 empty ack word", 128'(ack_word), 128'h3FF);

        // R10 attribute stored
        op(1, 5, cmd(0, 8'h08, 1, 12), 0, 0, 0);
        op(0, 0, 0, 1, 3, 12);
        chk("R10 attr returned", 128'(ack_secure), 128'd1);
        chk("R10 word", 128'(ack_word), 128'((5 << 10) | 12));

        // R11 write and ack same slot same cycle (target 0 id 3 from src 0)
        op(1, 0, cmd(0, 8'h01, 0, 3), 1, 0, 3);
        chk("R11 ack reports old", 128'(ack_word), 128'(3));
        chk("R11 new request kept", 128'(pend_level[0*NI+3]), 128'd1);
        op(0, 0, 0, 1, 0, 3);
        chk("R11 second ack valid", 128'(ack_valid), 128'd1);

        // random traffic compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            op($urandom_range(0, 1), $urandom_range(0, 7),
               cmd($urandom_range(0, 3), $urandom_range(0, 255), $urandom_range(0, 1),
                   $urandom_range(0, 3)),
               $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3));
        end
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule